// File: doc/BRIEF.md
# Edge Timestamp Capture Unit

This block records when transitions happen on an external input. The input is passed through a two-stage synchronizer, and transitions are found by comparing the synchronized value with a delayed copy. A mode field decides which transitions count as capture events: every edge, only falling edges, only rising edges, or every 4th or every 16th rising edge. For each capture event, the block stores the value of one of two 16-bit free-running time bases in a four-entry first-in first-out store. A select bit picks the time base.

Software reads the oldest stored value on a read-data bus and removes it with a one-cycle read strobe. A status bit shows that the store holds data. A sticky flag records any capture that was lost because the store was full. An interrupt pulse fires when the number of stored entries reaches a programmed level of 1 to 4. A separate event pulse follows every capture event, so the pin can also serve as a plain external interrupt source.

Top module: `icap_unit`

## Requirements
- R1: After reset, `not_empty_o`, `ovf_o`, `irq_o` and `evt_o` are 0 and `rd_data_o` is 0.
- R2: With `cfg_mode_i` = 3 (rising), each 0-to-1 transition of `pin_i` stores a timer value and falling transitions store nothing. `evt_o` pulses in the third clock cycle after the pin change. The stored value is the timer bus value present in the cycle before that pulse.
- R3: With `cfg_mode_i` = 2 (falling), only 1-to-0 transitions of `pin_i` are captured.
- R4: With `cfg_mode_i` = 1 (both), every transition of `pin_i` is captured.
- R5: With `cfg_mode_i` = 4, only every 4th rising transition is captured.
- R6: With `cfg_mode_i` = 5, only every 16th rising transition is captured.
- R7: `cfg_tsel_i` = 0 stores `tbase_a_i` and `cfg_tsel_i` = 1 stores `tbase_b_i`.
- R8: Up to 4 values are held. `rd_data_o` shows the oldest value, and a one-cycle `rd_i` removes it, so values are read back in capture order.
- R9: A capture event that occurs while 4 entries are held is dropped and sets `ovf_o`. `ovf_o` stays set until a one-cycle `ovf_clr_i` clears it.
- R10: When empty, `rd_data_o` is 0, and a pulse on `rd_i` changes nothing: the next capture is read back correctly.
- R11: `irq_o` is a one-cycle pulse that fires when a capture raises the occupancy to `cfg_ithr_i`+1.
- R12: `evt_o` pulses for every capture event, including events dropped on overflow.
- R13: Modes 0, 6 and 7 capture nothing. The edge prescaler count restarts from zero whenever the mode changes or the unit is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Asynchronous capture input |
| tbase_a_i | input | 16 | Time base A value |
| tbase_b_i | input | 16 | Time base B value |
| cfg_mode_i | input | 3 | Capture mode (0 off, 1 both, 2 fall, 3 rise, 4 every 4th rise, 5 every 16th rise) |
| cfg_tsel_i | input | 1 | Time base select (0 = A, 1 = B) |
| cfg_ithr_i | input | 2 | Interrupt level minus one |
| rd_i | input | 1 | Read strobe, removes the oldest entry |
| ovf_clr_i | input | 1 | Clears the overflow flag |
| rd_data_o | output | 16 | Oldest stored value, 0 when empty |
| not_empty_o | output | 1 | Store holds at least one value |
| ovf_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Level-reached interrupt pulse |
| evt_o | output | 1 | Capture event pulse |

## Verification
The assertions check on every cycle that:
- the interrupt is a single-cycle pulse, always coincides with an event pulse and never fires while the store is empty;
- an empty store presents zero;
- the overflow flag holds until it is cleared;
- the off mode yields no events.

Only the bench scenarios can show the rest: which transitions each mode qualifies, the prescaler divide counts and their restart on a mode change, the time base selection, first-in first-out ordering, and that a dropped capture really is lost.

// File: rtl/icap_pkg.sv
package icap_pkg;
  typedef enum logic [2:0] {
    ICM_OFF    = 3'd0,
    ICM_BOTH   = 3'd1,
    ICM_FALL   = 3'd2,
    ICM_RISE   = 3'd3,
    ICM_RISE4  = 3'd4,
    ICM_RISE16 = 3'd5
  } icap_mode_e;
endpackage

// File: rtl/icap_rst_sync.sv
module icap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sn_o = chain_q[STAGES-1];
endmodule

// File: rtl/icap_sync_edge.sv
module icap_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  // sh_q[STAGES-1] is the synchronized level, sh_q[STAGES] its one-cycle delay
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb sh_d = {sh_q[STAGES-1:0], pin_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] & sh_q[STAGES];
endmodule

// File: rtl/icap_qual.sv
module icap_qual
  import icap_pkg::*;
#(
  parameter int DIV_LO = 4,
  parameter int DIV_HI = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode_i,
  input  logic       rise_i,
  input  logic       fall_i,
  output logic       evt_o
);
  localparam int CW = $clog2(DIV_HI);

  icap_mode_e    mode_q;
  icap_mode_e    mode_cur;
  logic [CW-1:0] pcnt_q;
  logic [CW-1:0] pcnt_d;
  logic [CW-1:0] lim;
  logic          mode_chg;
  logic          presc;

  always_comb begin
    mode_cur = icap_mode_e'(mode_i);
    mode_chg = (mode_cur != mode_q);
    presc    = (mode_cur == ICM_RISE4) || (mode_cur == ICM_RISE16);
    lim      = (mode_cur == ICM_RISE4) ? CW'(DIV_LO - 1) : CW'(DIV_HI - 1);
    evt_o    = 1'b0;
    pcnt_d   = pcnt_q;
    case (mode_cur)
      ICM_BOTH: evt_o = rise_i | fall_i;
      ICM_FALL: evt_o = fall_i;
      ICM_RISE: evt_o = rise_i;
      default:  evt_o = 1'b0;
    endcase
    if (presc && rise_i && !mode_chg) begin
      if (pcnt_q == lim) begin
        evt_o  = 1'b1;
        pcnt_d = '0;
      end else begin
        pcnt_d = pcnt_q + CW'(1);
      end
    end
    if (mode_chg || !presc) pcnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= ICM_OFF;
      pcnt_q <= '0;
    end else begin
      mode_q <= mode_cur;
      pcnt_q <= pcnt_d;
    end
  end
endmodule

// File: rtl/icap_fifo.sv
module icap_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push_i,
  input  logic [W-1:0]               data_i,
  input  logic                       pop_i,
  output logic [W-1:0]               head_o,
  output logic [$clog2(DEPTH+1)-1:0] count_o,
  output logic                       empty_o,
  output logic                       accept_o,
  output logic                       pop_o
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          full;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    full     = (cnt_q == CW'(DEPTH));
    empty_o  = (cnt_q == '0);
    pop_o    = pop_i && !empty_o;
    accept_o = push_i && (!full || pop_o);
    wp_d     = accept_o ? ptr_inc(wp_q) : wp_q;
    rp_d     = pop_o ? ptr_inc(rp_q) : rp_q;
    cnt_d    = cnt_q;
    if (accept_o && !pop_o)      cnt_d = cnt_q + CW'(1);
    else if (!accept_o && pop_o) cnt_d = cnt_q - CW'(1);
    head_o   = empty_o ? '0 : mem[rp_q];
    count_o  = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept_o) mem[wp_q] <= data_i;
  end
endmodule

// File: rtl/icap_unit.sv
module icap_unit #(
  parameter int TW          = 16,
  parameter int DEPTH       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_LO      = 4,
  parameter int DIV_HI      = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pin_i,
  input  logic [TW-1:0]            tbase_a_i,
  input  logic [TW-1:0]            tbase_b_i,
  input  logic [2:0]               cfg_mode_i,
  input  logic                     cfg_tsel_i,
  input  logic [$clog2(DEPTH)-1:0] cfg_ithr_i,
  input  logic                     rd_i,
  input  logic                     ovf_clr_i,
  output logic [TW-1:0]            rd_data_o,
  output logic                     not_empty_o,
  output logic                     ovf_o,
  output logic                     irq_o,
  output logic                     evt_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic          rst_sn;
  logic          rise, fall, cap_evt;
  logic [TW-1:0] tsel_val;
  logic [CW-1:0] occ;
  logic          empty, accept, pop_eff;
  logic [CW-1:0] level;
  logic          ovf_q, ovf_d, irq_q, irq_d, evt_q, evt_d;

  icap_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn_o(rst_sn)
  );

  icap_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_sn), .pin_i(pin_i), .rise_o(rise), .fall_o(fall)
  );

  icap_qual #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_qual (
    .clk(clk), .rst_n(rst_sn), .mode_i(cfg_mode_i),
    .rise_i(rise), .fall_i(fall), .evt_o(cap_evt)
  );

  assign tsel_val = cfg_tsel_i ? tbase_b_i : tbase_a_i;

  icap_fifo #(.W(TW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_sn), .push_i(cap_evt), .data_i(tsel_val),
    .pop_i(rd_i), .head_o(rd_data_o), .count_o(occ), .empty_o(empty),
    .accept_o(accept), .pop_o(pop_eff)
  );

  always_comb begin
    level = CW'(cfg_ithr_i) + CW'(1);
    ovf_d = ovf_q;
    if (ovf_clr_i)           ovf_d = 1'b0;
    if (cap_evt && !accept)  ovf_d = 1'b1;
    irq_d = accept && !pop_eff && ((occ + CW'(1)) == level);
    evt_d = cap_evt;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      ovf_q <= 1'b0;
      irq_q <= 1'b0;
      evt_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      irq_q <= irq_d;
      evt_q <= evt_d;
    end
  end

  assign not_empty_o = !empty;
  assign ovf_o       = ovf_q;
  assign irq_o       = irq_q;
  assign evt_o       = evt_q;
endmodule

// File: rtl/icap_chk.sv
module icap_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  cfg_mode_i,
  input logic        ovf_clr_i,
  input logic [15:0] rd_data_o,
  input logic        not_empty_o,
  input logic        ovf_o,
  input logic        irq_o,
  input logic        evt_o
);
  // R11
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);
  // R11
  irq_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> not_empty_o);
  // R12
  irq_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> evt_o);
  // R10
  empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !not_empty_o |-> (rd_data_o == 16'd0));
  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_o && !ovf_clr_i) |=> ovf_o);
  // R13
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode_i == 3'd0) |=> !evt_o);
endmodule

bind icap_unit icap_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_mode_i(cfg_mode_i), .ovf_clr_i(ovf_clr_i),
  .rd_data_o(rd_data_o), .not_empty_o(not_empty_o), .ovf_o(ovf_o),
  .irq_o(irq_o), .evt_o(evt_o)
);

// File: tb/tb_icap_unit.sv
`timescale 1ns/1ps
module tb_icap_unit;
  logic        clk = 1'b0;
  logic        rst_n, pin, tsel, rd, ovf_clr;
  logic [2:0]  mode;
  logic [1:0]  ithr;
  logic [15:0] ta, tb;
  logic [15:0] rd_data;
  logic        not_empty, ovf, irq, evt;

  always #2 clk = ~clk;

  icap_unit dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin), .tbase_a_i(ta), .tbase_b_i(tb),
    .cfg_mode_i(mode), .cfg_tsel_i(tsel), .cfg_ithr_i(ithr), .rd_i(rd),
    .ovf_clr_i(ovf_clr), .rd_data_o(rd_data), .not_empty_o(not_empty),
    .ovf_o(ovf), .irq_o(irq), .evt_o(evt)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;
  logic [15:0] exp_q[$];
  int  pcnt  = 0;
  bit  pin_m = 0;
  bit  ovf_m = 0;

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // driver: predicts the event and pushes the expected timestamp
  task automatic drive_pin(logic v, logic [15:0] a, logic [15:0] b, string req);
    bit r, f, e, acc, irq_e;
    r = v && !pin_m;
    f = !v && pin_m;
    e = 0;
    case (mode)
      3'd1: e = r | f;
      3'd2: e = f;
      3'd3: e = r;
      3'd4, 3'd5: if (r) begin
        pcnt++;
        if (pcnt == ((mode == 3'd4) ? 4 : 16)) begin e = 1; pcnt = 0; end
      end
      default: e = 0;
    endcase
    acc = e && (exp_q.size() < 4);
    if (acc) exp_q.push_back(tsel ? b : a);
    if (e && !acc) ovf_m = 1;
    irq_e = acc && (exp_q.size() == int'(ithr) + 1);
    pin_m = v;
    pin = v; ta = a; tb = b;
    repeat (3) @(negedge clk);
    chk({req, " evt"}, 16'(evt), 16'(e));
    chk("R11 irq", 16'(irq), 16'(irq_e));
    chk("R9 ovf", 16'(ovf), 16'(ovf_m));
    chk("R8 not_empty", 16'(not_empty), 16'(exp_q.size() > 0));
    @(negedge clk);
    chk("R11 irq width", 16'(irq), 16'd0);
  endtask

  task automatic pulse(logic [15:0] a, logic [15:0] b, string req);
    drive_pin(1'b1, a, b, req);
    drive_pin(1'b0, a, b, req);
  endtask

  // monitor: pops the scoreboard and compares with the read port
  task automatic read_one(string req);
    chk({req, " not_empty"}, 16'(not_empty), 16'(exp_q.size() > 0));
    if (exp_q.size() > 0) chk(req, rd_data, exp_q.pop_front());
    else                  chk({req, " empty data"}, rd_data, 16'd0);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic set_mode(logic [2:0] m);
    mode = m;
    pcnt = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
  end

  initial begin
    rst_n = 0; pin = 0; tsel = 0; rd = 0; ovf_clr = 0;
    mode = 3'd0; ithr = 2'd0; ta = '0; tb = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1
    chk("R1 not_empty", 16'(not_empty), 16'd0);
    chk("R1 ovf", 16'(ovf), 16'd0);
    chk("R1 irq", 16'(irq), 16'd0);
    chk("R1 evt", 16'(evt), 16'd0);
    chk("R1 rd_data", rd_data, 16'd0);

    // R2 rising only, threshold one entry
    set_mode(3'd3);
    drive_pin(1'b1, 16'h0100, 16'h9999, "R2 rise");
    drive_pin(1'b0, 16'h0200, 16'h9999, "R2 fall ignored");
    read_one("R2 data");

    // R3 falling only
    set_mode(3'd2);
    drive_pin(1'b1, 16'h0111, 16'h9999, "R3 rise ignored");
    drive_pin(1'b0, 16'h0300, 16'h9999, "R3 fall");
    read_one("R3 data");

    // R4 both edges, threshold two entries
    ithr = 2'd1;
    set_mode(3'd1);
    drive_pin(1'b1, 16'h0400, 16'h9999, "R4 rise");
    drive_pin(1'b0, 16'h0500, 16'h9999, "R4 fall");
    read_one("R8 order first");
    read_one("R8 order second");

    // R7 time base select
    tsel = 1'b1;
    ithr = 2'd0;
    set_mode(3'd3);
    pulse(16'h0001, 16'hBEEF, "R7 select b");
    read_one("R7 data b");
    tsel = 1'b0;

    // R5 every 4th rising edge
    set_mode(3'd4);
    for (int i = 0; i < 8; i++) pulse(16'(16'h1000 + i), 16'h9999, "R5 div4");
    read_one("R5 data 4th");
    read_one("R5 data 8th");

    // R13 restart on off and mode change
    pulse(16'h2000, 16'h9999, "R13 pre");
    pulse(16'h2001, 16'h9999, "R13 pre");
    set_mode(3'd0);
    pulse(16'h2002, 16'h9999, "R13 off");
    set_mode(3'd4);
    for (int i = 0; i < 4; i++) pulse(16'(16'h2100 + i), 16'h9999, "R13 restart");
    read_one("R13 data");

    // R6 every 16th rising edge
    set_mode(3'd5);
    for (int i = 0; i < 16; i++) pulse(16'(16'h3000 + i), 16'h9999, "R6 div16");
    read_one("R6 data");

    // R10 empty read has no effect
    read_one("R10 empty read");
    read_one("R10 empty read again");
    set_mode(3'd3);
    pulse(16'h4444, 16'h9999, "R10 after empty");
    read_one("R10 data after empty");

    // R9 / R12 overflow with level 4
    ithr = 2'd3;
    for (int i = 0; i < 5; i++) pulse(16'(16'h5000 + i), 16'h9999, "R12 evt");
    repeat (5) @(negedge clk);
    chk("R9 ovf held", 16'(ovf), 16'd1);
    for (int i = 0; i < 4; i++) read_one("R9 kept data");
    read_one("R9 dropped value absent");
    chk("R9 ovf after reads", 16'(ovf), 16'd1);
    ovf_clr = 1'b1;
    @(negedge clk);
    ovf_clr = 1'b0;
    ovf_m = 0;
    chk("R9 ovf cleared", 16'(ovf), 16'd0);

    repeat (4) @(negedge clk);
    summary();
  end
endmodule